// File: doc/BRIEF.md
# Modulo-Indexed Direct-Mapped Cache

This block is a write-back, direct-mapped cache placed between a word-addressed processor port and a main-memory port that moves whole blocks only. Each block is four 32-bit words. The line count does not have to be a power of two. A block address is therefore split by arithmetic rather than by a bit slice. The remainder of the block address divided by the line count selects the line. The quotient is stored as the tag. Multiplying the tag by the line count and adding the line number gives the block address back, and eviction uses this to find where a dirty line goes.

The processor raises `cpu_valid` and keeps the request fields steady until it sees `cpu_ready`. A hit completes in the same cycle. A miss holds `cpu_ready` low while the controller works through its states:

- **IDLE**: the state where lookups are made.
- **EVICT**: the dirty victim line is written back to memory.
- **FILL**: the missed block is read into its line.
- **PROBE**: reached only in paired mode. It checks whether block+1 is already present in the next line (taken modulo the line count). If it is not, the controller takes the EVICT and FILL path again for block+1.

The transitions are:

- IDLE→EVICT on a miss whose line is dirty.
- IDLE→FILL on a miss whose line is clean.
- EVICT→FILL when memory acknowledges.
- FILL→IDLE when memory acknowledges and no paired fetch is pending.
- FILL→PROBE when memory acknowledges and a paired fetch is pending.
- PROBE→IDLE when block+1 is present.
- PROBE→EVICT when block+1 is absent and its line is dirty.
- PROBE→FILL when block+1 is absent and its line is clean.

After returning to IDLE, the request that is still being held hits.

Top module: `dmcache_top`

## Requirements
- R1: A block goes to line (block mod LINES) with stored tag (block div LINES). With LINES=5, blocks 0 and 5 compete for line 0, while blocks 1 and 5 can be resident together.
- R2: The word address is block*4 + offset. The two low bits of `cpu_addr` pick the word within the block, and word w sits at bits [32w+31:32w] of the memory data buses.
- R3: A hit raises `cpu_ready` in the cycle `cpu_valid` is sampled high and causes no memory request. A read hit returns the addressed word on `cpu_rdata`.
- R4: A read miss issues a block read (`mem_we`=0) at the missed block address. `cpu_ready` follows after the fill, with the word taken from the fetched block.
- R5: A miss whose line is valid and dirty first writes the whole line back (`mem_we`=1) at address tag*LINES+line. The block read follows.
- R6: A write hit updates only the addressed word and marks the line dirty, with no memory request.
- R7: A write miss allocates the line: the block is fetched, the word is merged, and a later eviction writes back the merged block.
- R8: When `pair_fill_en` is high at a miss, block+1 is also brought into line ((line+1) mod LINES), wrapping from the last line to line 0. The fetch is skipped when that line already holds block+1. A dirty occupant of that line is written back first.
- R9: After reset every line is invalid and clean, so the first access misses with no write-back, and no memory request is made during reset.
- R10: Once `mem_req` is raised, it stays high with `mem_we`, `mem_blk_addr` and `mem_wdata` unchanged until `mem_ack`.
- R11: `cpu_ready` is only high while `cpu_valid` is high. A write-back is always followed directly by a block read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_fill_en | input | 1 | Fetch the next sequential block too on a miss |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read word, valid with cpu_ready |
| mem_req | output | 1 | Memory block transfer requested |
| mem_we | output | 1 | Transfer is a write-back |
| mem_blk_addr | output | ADDR_W-2 | Block address of the transfer |
| mem_wdata | output | 128 | Block written back |
| mem_ack | input | 1 | Transfer done; read data valid |
| mem_rdata | input | 128 | Block read from memory |

## Verification
The interesting collision is a paired fetch whose second line holds dirty data. Two functions then interleave inside one miss: the sequential fill and a dirty eviction.

The bench provokes this by dirtying block 4 with a write hit and then missing on block 8 with paired mode on. It also covers the skip case, where block+1 is already resident, and the wrap from line 4 to line 0.

A scoreboard holds the expected ordered list of block transfers, each with its direction and address. As every acknowledge happens, the scoreboard pops the next entry. For each write-back, it compares the written block against a word-level model of what the processor stored.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_PROBE
    } dmc_state_e;
endpackage

// File: rtl/dmc_index.sv
// Splits a block address into line number (remainder) and tag (quotient).
module dmc_index #(
    parameter int BLK_W = 14,
    parameter int LINES = 5,
    parameter int IDX_W = 3,
    parameter int TAG_W = 12
) (
    input  logic [BLK_W-1:0] blk,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    localparam logic [BLK_W-1:0] DIV = BLK_W'(LINES);

    assign idx = IDX_W'(blk % DIV);
    assign tag = TAG_W'(blk / DIV);
endmodule

// File: rtl/dmc_lines.sv
// Line storage: valid, dirty, tag and block data; one read, one write port.
module dmc_lines #(
    parameter int LINES    = 5,
    parameter int IDX_W    = 3,
    parameter int TAG_W    = 12,
    parameter int BLK_BITS = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    ridx,
    output logic                rvalid,
    output logic                rdirty,
    output logic [TAG_W-1:0]    rtag,
    output logic [BLK_BITS-1:0] rdata,
    input  logic                we,
    input  logic [IDX_W-1:0]    widx,
    input  logic                wdirty,
    input  logic [TAG_W-1:0]    wtag,
    input  logic [BLK_BITS-1:0] wdata
);
    logic [LINES-1:0]    valid_q;
    logic [LINES-1:0]    dirty_q;
    logic [TAG_W-1:0]    tag_q  [LINES];
    logic [BLK_BITS-1:0] data_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (we) begin
            valid_q[widx] <= 1'b1;
            dirty_q[widx] <= wdirty;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[widx]  <= wtag;
            data_q[widx] <= wdata;
        end
    end

    assign rvalid = valid_q[ridx];
    assign rdirty = dirty_q[ridx];
    assign rtag   = tag_q[ridx];
    assign rdata  = data_q[ridx];
endmodule

// File: rtl/dmcache_top.sv
module dmcache_top
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WORDS  = 4,
    parameter int LINES  = 5,
    localparam int OFF_W    = $clog2(WORDS),
    localparam int BLK_W    = ADDR_W - OFF_W,
    localparam int BLK_BITS = WORDS * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pair_fill_en,
    input  logic                cpu_valid,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [WORD_W-1:0]   cpu_wdata,
    output logic                cpu_ready,
    output logic [WORD_W-1:0]   cpu_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [BLK_W-1:0]    mem_blk_addr,
    output logic [BLK_BITS-1:0] mem_wdata,
    input  logic                mem_ack,
    input  logic [BLK_BITS-1:0] mem_rdata
);
    localparam int IDX_W   = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int TAG_W   = $clog2(((2 ** BLK_W) - 1) / LINES + 1);
    localparam bit PAIR_OK = (LINES > 1);

    dmc_state_e state_q, state_nx;
    logic [BLK_W-1:0] cur_blk_q, cur_blk_nx;
    logic             pair_q, pair_nx;

    logic [BLK_W-1:0]    cpu_blk, look_blk, victim_blk;
    logic [OFF_W-1:0]    cpu_off;
    logic [IDX_W-1:0]    look_idx;
    logic [TAG_W-1:0]    look_tag;
    logic                ln_valid, ln_dirty, hit;
    logic [TAG_W-1:0]    ln_tag;
    logic [BLK_BITS-1:0] ln_data, merged;
    logic                st_we, st_dirty;
    logic [BLK_BITS-1:0] st_data;

    assign cpu_blk  = cpu_addr[ADDR_W-1:OFF_W];
    assign cpu_off  = cpu_addr[OFF_W-1:0];
    assign look_blk = (state_q == ST_IDLE) ? cpu_blk : cur_blk_q;

    dmc_index #(.BLK_W(BLK_W), .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) idx_i (
        .blk(look_blk), .idx(look_idx), .tag(look_tag)
    );

    dmc_lines #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_BITS(BLK_BITS)) lines_i (
        .clk(clk), .rst_n(rst_n),
        .ridx(look_idx), .rvalid(ln_valid), .rdirty(ln_dirty), .rtag(ln_tag), .rdata(ln_data),
        .we(st_we), .widx(look_idx), .wdirty(st_dirty), .wtag(look_tag), .wdata(st_data)
    );

    assign hit        = ln_valid && (ln_tag == look_tag);
    assign victim_blk = BLK_W'(ln_tag) * BLK_W'(LINES) + BLK_W'(look_idx);

    always_comb begin
        merged = ln_data;
        merged[cpu_off*WORD_W +: WORD_W] = cpu_wdata;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_blk_q <= '0;
            pair_q    <= 1'b0;
        end else begin
            state_q   <= state_nx;
            cur_blk_q <= cur_blk_nx;
            pair_q    <= pair_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx   = state_q;
        cur_blk_nx = cur_blk_q;
        pair_nx    = pair_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_valid && !hit) begin
                    cur_blk_nx = cpu_blk;
                    pair_nx    = pair_fill_en && PAIR_OK;
                    state_nx   = (ln_valid && ln_dirty) ? ST_EVICT : ST_FILL;
                end
            end
            ST_EVICT: begin
                if (mem_ack) state_nx = ST_FILL;
            end
            ST_FILL: begin
                if (mem_ack) begin
                    if (pair_q) begin
                        pair_nx    = 1'b0;
                        cur_blk_nx = cur_blk_q + 1'b1;
                        state_nx   = ST_PROBE;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            ST_PROBE: begin
                if (hit)                       state_nx = ST_IDLE;
                else if (ln_valid && ln_dirty) state_nx = ST_EVICT;
                else                           state_nx = ST_FILL;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cpu_ready    = 1'b0;
        cpu_rdata    = ln_data[cpu_off*WORD_W +: WORD_W];
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_blk_addr = cur_blk_q;
        mem_wdata    = ln_data;
        st_we        = 1'b0;
        st_dirty     = 1'b0;
        st_data      = mem_rdata;
        unique case (state_q)
            ST_IDLE: begin
                cpu_ready = cpu_valid && hit;
                if (cpu_valid && hit && cpu_we) begin
                    st_we    = 1'b1;
                    st_dirty = 1'b1;
                    st_data  = merged;
                end
            end
            ST_EVICT: begin
                mem_req      = 1'b1;
                mem_we       = 1'b1;
                mem_blk_addr = victim_blk;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                st_we   = mem_ack;
            end
            ST_PROBE: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/dmc_chk.sv
module dmc_chk #(
    parameter int BLK_W    = 14,
    parameter int BLK_BITS = 128
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cpu_valid,
    input logic                cpu_we,
    input logic                cpu_ready,
    input logic                mem_req,
    input logic                mem_we,
    input logic [BLK_W-1:0]    mem_blk_addr,
    input logic [BLK_BITS-1:0] mem_wdata,
    input logic                mem_ack
);
    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_blk_addr) && $stable(mem_wdata));

    // R11
    ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_valid);

    // R3
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

    // R6
    write_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && cpu_we |=> !mem_req);

    // R5
    evict_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we);
endmodule

bind dmcache_top dmc_chk #(.BLK_W(BLK_W), .BLK_BITS(BLK_BITS)) chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_blk_addr(mem_blk_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack)
);

// File: tb/dmcache_top_tb_top.sv
`timescale 1ns/1ps
module dmcache_top_tb_top;
    localparam int ADDR_W = 16;
    localparam int BLK_W  = 14;
    localparam int BB     = 128;

    typedef struct packed {
        logic             we;
        logic [BLK_W-1:0] blk;
    } xfer_t;

    logic clk = 0, rst_n = 0, pair_fill_en = 0;
    logic cpu_valid = 0, cpu_we = 0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0, cpu_rdata;
    logic cpu_ready, mem_req, mem_we, mem_ack = 0;
    logic [BLK_W-1:0] mem_blk_addr;
    logic [BB-1:0] mem_wdata, mem_rdata = '0;

    int n_chk = 0, n_fail = 0;
    xfer_t exp_q[$];
    logic [BB-1:0] bmem [int];
    logic [31:0] ref_w [int];

    always #10 clk = ~clk;

    dmcache_top dut_i (
        .clk(clk), .rst_n(rst_n), .pair_fill_en(pair_fill_en),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_blk_addr(mem_blk_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] word_init(int blk, int w);
        return 32'hC000_0000 | 32'(blk << 4) | 32'(w);
    endfunction

    function automatic logic [BB-1:0] blk_mem(int blk);
        logic [BB-1:0] b;
        if (bmem.exists(blk)) return bmem[blk];
        for (int w = 0; w < 4; w++) b[w*32 +: 32] = word_init(blk, w);
        return b;
    endfunction

    function automatic logic [31:0] ref_word(int a);
        if (ref_w.exists(a)) return ref_w[a];
        return word_init(a >> 2, a & 3);
    endfunction

    function automatic logic [BB-1:0] exp_block(int blk);
        logic [BB-1:0] b;
        for (int w = 0; w < 4; w++) b[w*32 +: 32] = ref_word(blk*4 + w);
        return b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [BB-1:0] act, input logic [BB-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_x(input bit we, input int blk);
        xfer_t e;
        e.we  = we;
        e.blk = BLK_W'(blk);
        exp_q.push_back(e);
    endtask

    // Monitor: memory responder and scoreboard of block transfers
    initial begin
        int wait_c;
        xfer_t e;
        wait_c = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 0;
                wait_c  = 0;
            end else if (mem_req) begin
                wait_c++;
                if (wait_c == 2) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R11", "unexpected transfer", {mem_we, mem_blk_addr}, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(e.we == mem_we && e.blk == mem_blk_addr, "R4/R5/R8", "transfer kind/addr",
                            {mem_we, mem_blk_addr}, {e.we, e.blk});
                    end
                    if (mem_we) begin
                        chk(mem_wdata == exp_block(int'(mem_blk_addr)), "R5/R7", "write-back block",
                            mem_wdata, exp_block(int'(mem_blk_addr)));
                        bmem[int'(mem_blk_addr)] = mem_wdata;
                    end else begin
                        mem_rdata = blk_mem(int'(mem_blk_addr));
                    end
                    mem_ack = 1;
                end
            end
        end
    end

    task automatic access(input bit we, input int blk, input int off, input logic [31:0] wd,
                          input string req, input bit want_hit);
        int waits;
        int a;
        logic [31:0] exp;
        waits = 0;
        a = blk*4 + off;
        exp = ref_word(a);
        @(negedge clk);
        cpu_valid = 1; cpu_we = we; cpu_addr = ADDR_W'(a); cpu_wdata = wd;
        #1;
        while (!cpu_ready && waits < 1000) begin
            @(negedge clk); #1; waits++;
        end
        if (!we) chk(cpu_rdata == exp, req, "read data", cpu_rdata, exp);
        if (want_hit) chk(waits == 0, req, "hit latency", waits, 0);
        else          chk(waits > 0, req, "miss stalls", waits, 1);
        @(posedge clk); #1;
        cpu_valid = 0;
        if (we) ref_w[a] = wd;
        chk(exp_q.size() == 0, req, "pending transfers", exp_q.size(), 0);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: no memory activity during reset
        chk(mem_req == 0 && cpu_ready == 0, "R9", "reset outputs", {mem_req, cpu_ready}, 0);
        rst_n = 1;

        // R9 R4: first access misses, plain read, no write-back
        expect_x(0, 0);
        access(0, 0, 1, 0, "R9 R4", 0);
        // R3 R2: hit on another word of the same block
        access(0, 0, 3, 0, "R3 R2", 1);
        // R6: write hit, silent
        access(1, 0, 2, 32'hDEAD_0002, "R6", 1);
        access(0, 0, 2, 0, "R6 readback", 1);
        // R1 R5: block 5 shares line 0, dirty block 0 written back first
        expect_x(1, 0); expect_x(0, 5);
        access(0, 5, 0, 0, "R1 R5", 0);
        expect_x(0, 1);
        access(0, 1, 2, 0, "R1 line1", 0);
        access(0, 5, 3, 0, "R1 coexist", 1);
        // R7: write miss allocates then merges
        expect_x(0, 12);
        access(1, 12, 1, 32'h1234_5678, "R7 alloc", 0);
        access(0, 12, 1, 0, "R7 merged", 1);
        expect_x(1, 12); expect_x(0, 7);
        access(0, 7, 0, 0, "R7 evict", 0);

        // R8: paired fill into next line
        pair_fill_en = 1;
        expect_x(0, 3); expect_x(0, 4);
        access(0, 3, 0, 0, "R8 pair", 0);
        pair_fill_en = 0;
        access(1, 4, 0, 32'hBEEF_0004, "R8 second resident", 1);
        // R8 with a dirty second line
        pair_fill_en = 1;
        expect_x(0, 8); expect_x(1, 4); expect_x(0, 9);
        access(0, 8, 2, 0, "R8 dirty second", 0);
        access(0, 9, 1, 0, "R8 second hit", 1);
        // R8 skip: block 1 already in line 1
        expect_x(0, 0);
        access(0, 0, 0, 0, "R8 skip", 0);
        access(0, 1, 0, 0, "R8 skip hit", 1);
        // R8 R1 wrap: line 4 -> line 0
        expect_x(0, 14); expect_x(0, 15);
        access(0, 14, 3, 0, "R8 wrap", 0);
        access(0, 15, 2, 0, "R8 wrap hit", 1);
        pair_fill_en = 0;

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule